// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block walks a linked list of frame descriptors for a bank of display DMA channels. On every frame-start pulse it visits the channels in ascending order. For each enabled channel it reads a four-word descriptor from memory through a valid/ready request/response port. The four words are the link to the next descriptor, the frame source address, a frame tag and a command word. The link that was read becomes the pointer for the following frame, so a circular chain of descriptors replays on its own.

Software can redirect the next fetch of any channel through a one-shot branch register. A pending branch replaces the stored link for exactly one fetch. It can optionally raise a branch event, and it clears its request flag when used. After each channel has been handled, the block checks that channel's source address. A source of zero, or one outside the memory window, produces a bus-error event tagged with the channel number. A per-channel load pulse reports the length and palette flag decoded from the command word. A done pulse closes the frame.

The memory request port follows valid/ready rules. The address stays stable while `mem_req_valid` is high and `mem_req_ready` is low. Only one request is outstanding at a time: no new request is raised while `mem_rsp_ready` is high, and a response counts only in a cycle where both `mem_rsp_valid` and `mem_rsp_ready` are high. The memory may stall either channel of the handshake for any number of cycles.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset every channel register and branch register reads zero, no memory request is raised, `fetch_busy` is low and no event pulse is active.
- R2: Register map: link word at 0x200+16*ch, source at +4, tag at +8, command at +0xC, and branch register at 0x100+4*ch. A write to the link word stores the data ANDed with 0xFFFFFFF0, and a write to the branch register stores it ANDed with 0xFFFFFFF3. Writes to the source, tag and command words have no effect, and unmapped offsets read zero.
- R3: A frame-start pulse accepted while idle clears the source word of every channel, including disabled ones. A frame-start pulse that arrives while a frame is in progress is ignored.
- R4: Disabled channels are skipped and enabled channels are fetched in ascending order. Each fetch reads the words at pointer, +4, +8 and +0xC in that order and stores them as link, source, tag and command.
- R5: If branch bit 0 is set when a channel is visited, the fetch pointer is branch bits 31:4 (low four bits zero) and bit 0 is cleared. If bit 1 is also set, `branch_evt` pulses with `branch_ch` equal to the channel.
- R6: With branch bit 0 clear, the fetch pointer is the stored link word, so successive frames follow the descriptor chain.
- R7: A fetch is made only when pointer >= MEM_BASE and pointer+16 <= MEM_BASE+MEM_SIZE. Otherwise the channel issues no request and its source stays zero.
- R8: After an enabled channel is handled, a source of zero, below MEM_BASE, or above MEM_BASE+MEM_SIZE causes one `bus_err_evt` pulse with `bus_err_ch` equal to the channel. A source exactly at MEM_BASE+MEM_SIZE is accepted.
- R9: For each channel actually fetched, `load_evt` pulses with `load_len` = command bits 20:2 (command AND 0x1FFFFC) and `load_pal` = command bit 26.
- R10: `frame_done` pulses exactly once per accepted frame start, after the last channel. `fetch_busy` is high from that start until the done pulse and low afterwards.
- R11: The request address stays stable while it waits for ready, and no request is raised while a response is awaited.
- R12: A software write to a channel's link word in the same cycle that the fetched link word for that channel is stored takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start pulse |
| ch_enable | input | NUM_CH | Per-channel enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req_valid | output | 1 | Memory word read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Fetcher accepts response |
| mem_rsp_data | input | 32 | Response word |
| fetch_busy | output | 1 | Frame walk in progress |
| frame_done | output | 1 | All channels handled for this frame |
| branch_evt | output | 1 | Branch-status event |
| branch_ch | output | CH_W | Channel of branch event |
| bus_err_evt | output | 1 | Bus-error event |
| bus_err_ch | output | CH_W | Channel of bus error |
| load_evt | output | 1 | Descriptor loaded |
| load_ch | output | CH_W | Channel of loaded descriptor |
| load_len | output | 21 | Transfer length from command |
| load_pal | output | 1 | Palette-load flag from command |

## Verification
Two updates can reach one channel's link word in the same clock edge. One is a software write through the register port. The other is the storing of the link word that the fetcher has just read from memory. The bench holds the memory response back until the first descriptor word of channel 0 is outstanding. It then releases the response and drives a register write to that link word in the same cycle. After the frame the bench reads the link word back: it must hold the masked software value, while the source word of the same fetch must still hold the value from memory.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DESC_WORDS = 4;

  localparam logic [WORD_W-1:0] LINK_WR_MASK = 32'hFFFF_FFF0;
  localparam logic [WORD_W-1:0] BRANCH_WR_MASK = 32'hFFFF_FFF3;
  localparam logic [20:0] LEN_MASK = 21'h1F_FFFC;

  localparam int unsigned BR_REQ_BIT = 0;
  localparam int unsigned BR_INT_BIT = 1;
  localparam int unsigned PAL_BIT = 26;

  localparam int unsigned CH_BLOCK_BASE = 'h200;
  localparam int unsigned BR_BLOCK_BASE = 'h100;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SCAN,
    SEQ_REQ,
    SEQ_WAIT,
    SEQ_CHECK
  } seq_state_e;
endpackage

// File: rtl/fd_window_check.sv
module fd_window_check #(
  parameter logic [31:0] BASE = 32'h1000_0000,
  parameter logic [31:0] SIZE = 32'h0000_1000,
  parameter int unsigned SPAN = 16
) (
  input  logic [31:0] addr,
  output logic        in_window
);
  localparam logic [32:0] LO = {1'b0, BASE};
  localparam logic [32:0] HI = {1'b0, BASE} + {1'b0, SIZE};

  logic [32:0] top_of_span;
  assign top_of_span = {1'b0, addr} + 33'(SPAN);
  assign in_window = ({1'b0, addr} >= LO) && (top_of_span <= HI);
endmodule

// File: rtl/fd_chan_regs.sv
module fd_chan_regs
  import fd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_link_we,
  input  logic              sw_br_we,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              clr_src,
  input  logic [DESC_WORDS-1:0] hw_we,
  input  logic [WORD_W-1:0] hw_wdata,
  input  logic              br_consume,
  output logic [WORD_W-1:0] link_q,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] tag_q,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] br_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= '0;
      src_q  <= '0;
      tag_q  <= '0;
      cmd_q  <= '0;
      br_q   <= '0;
    end else begin
      // software write to the link word outranks the fetched value
      if (sw_link_we)     link_q <= sw_wdata & LINK_WR_MASK;
      else if (hw_we[0])  link_q <= hw_wdata;

      if (clr_src)        src_q <= '0;
      else if (hw_we[1])  src_q <= hw_wdata;

      if (hw_we[2])       tag_q <= hw_wdata;
      if (hw_we[3])       cmd_q <= hw_wdata;

      if (sw_br_we)       br_q <= sw_wdata & BRANCH_WR_MASK;
      else if (br_consume) br_q[BR_REQ_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/fd_fetch_seq.sv
module fd_fetch_seq
  import fd_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CH_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [WORD_W-1:0] sel_link,
  input  logic [WORD_W-1:0] sel_br,
  input  logic [WORD_W-1:0] sel_src,
  input  logic [WORD_W-1:0] sel_cmd,
  output logic [WORD_W-1:0] next_ptr,
  input  logic              ptr_ok,
  input  logic              src_ok,
  output logic [CH_W-1:0]   cur_ch,
  output logic              clr_src,
  output logic [DESC_WORDS-1:0] hw_we,
  output logic              br_consume,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  output logic              fetch_busy,
  output logic              frame_done,
  output logic              branch_evt,
  output logic              bus_err_evt,
  output logic              load_evt,
  output logic [20:0]       load_len,
  output logic              load_pal
);
  seq_state_e        state;
  logic [CH_W-1:0]   ch;
  logic [1:0]        word;
  logic [WORD_W-1:0] ptr;
  logic              fetched;

  logic [NUM_CH:0] en_ext;
  logic            cur_en;
  logic            at_end;
  logic            br_hit;

  assign en_ext = {1'b0, ch_enable};
  assign cur_en = en_ext[ch];
  assign at_end = (ch == CH_W'(NUM_CH));
  assign cur_ch = ch;

  assign next_ptr = sel_br[BR_REQ_BIT] ? {sel_br[WORD_W-1:4], 4'b0000} : sel_link;

  assign br_hit      = (state == SEQ_SCAN) && !at_end && cur_en && sel_br[BR_REQ_BIT];
  assign br_consume  = br_hit;
  assign branch_evt  = br_hit && sel_br[BR_INT_BIT];

  assign clr_src       = (state == SEQ_IDLE) && frame_start;
  assign mem_req_valid = (state == SEQ_REQ);
  assign mem_req_addr  = ptr + {28'd0, word, 2'b00};
  assign mem_rsp_ready = (state == SEQ_WAIT);
  assign hw_we = (state == SEQ_WAIT && mem_rsp_valid) ? DESC_WORDS'(1) << word : '0;

  assign bus_err_evt = (state == SEQ_CHECK) && ((sel_src == '0) || !src_ok);
  assign load_evt    = (state == SEQ_CHECK) && fetched;
  assign load_len    = sel_cmd[20:0] & LEN_MASK;
  assign load_pal    = sel_cmd[PAL_BIT];

  assign frame_done = (state == SEQ_SCAN) && at_end;
  assign fetch_busy = (state != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      ch      <= '0;
      word    <= '0;
      ptr     <= '0;
      fetched <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (frame_start) begin
            ch    <= '0;
            state <= SEQ_SCAN;
          end
        end
        SEQ_SCAN: begin
          if (at_end) begin
            state <= SEQ_IDLE;
          end else if (!cur_en) begin
            ch <= ch + 1'b1;
          end else if (ptr_ok) begin
            ptr     <= next_ptr;
            word    <= '0;
            fetched <= 1'b1;
            state   <= SEQ_REQ;
          end else begin
            fetched <= 1'b0;
            state   <= SEQ_CHECK;
          end
        end
        SEQ_REQ: begin
          if (mem_req_ready) state <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (mem_rsp_valid) begin
            if (word == 2'(DESC_WORDS - 1)) begin
              state <= SEQ_CHECK;
            end else begin
              word  <= word + 1'b1;
              state <= SEQ_REQ;
            end
          end
        end
        SEQ_CHECK: begin
          ch    <= ch + 1'b1;
          state <= SEQ_SCAN;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher
  import fd_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter logic [31:0] MEM_BASE = 32'h1000_0000,
  parameter logic [31:0] MEM_SIZE = 32'h0000_1000,
  parameter int unsigned REG_AW = 12,
  localparam int unsigned CH_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              fetch_busy,
  output logic              frame_done,
  output logic              branch_evt,
  output logic [CH_W-1:0]   branch_ch,
  output logic              bus_err_evt,
  output logic [CH_W-1:0]   bus_err_ch,
  output logic              load_evt,
  output logic [CH_W-1:0]   load_ch,
  output logic [20:0]       load_len,
  output logic              load_pal
);
  logic [WORD_W-1:0] link_a [NUM_CH];
  logic [WORD_W-1:0] src_a  [NUM_CH];
  logic [WORD_W-1:0] tag_a  [NUM_CH];
  logic [WORD_W-1:0] cmd_a  [NUM_CH];
  logic [WORD_W-1:0] br_a   [NUM_CH];

  logic [CH_W-1:0]       cur_ch;
  logic                  clr_src;
  logic [DESC_WORDS-1:0] hw_we;
  logic                  br_consume;
  logic [WORD_W-1:0]     sel_link, sel_br, sel_src, sel_cmd, next_ptr;
  logic                  ptr_ok, src_ok;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic                  link_we, br_we, cons;
    logic [DESC_WORDS-1:0] hwe;

    assign link_we = reg_wr_en && (reg_addr == REG_AW'(CH_BLOCK_BASE + 16 * g));
    assign br_we   = reg_wr_en && (reg_addr == REG_AW'(BR_BLOCK_BASE + 4 * g));
    assign hwe     = (cur_ch == CH_W'(g)) ? hw_we : '0;
    assign cons    = br_consume && (cur_ch == CH_W'(g));

    fd_chan_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_link_we (link_we),
      .sw_br_we   (br_we),
      .sw_wdata   (reg_wdata),
      .clr_src    (clr_src),
      .hw_we      (hwe),
      .hw_wdata   (mem_rsp_data),
      .br_consume (cons),
      .link_q     (link_a[g]),
      .src_q      (src_a[g]),
      .tag_q      (tag_a[g]),
      .cmd_q      (cmd_a[g]),
      .br_q       (br_a[g])
    );
  end

  always_comb begin
    sel_link = '0;
    sel_br   = '0;
    sel_src  = '0;
    sel_cmd  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cur_ch == CH_W'(i)) begin
        sel_link = link_a[i];
        sel_br   = br_a[i];
        sel_src  = src_a[i];
        sel_cmd  = cmd_a[i];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == REG_AW'(CH_BLOCK_BASE + 16 * i))      reg_rdata = link_a[i];
      if (reg_addr == REG_AW'(CH_BLOCK_BASE + 16 * i + 4))  reg_rdata = src_a[i];
      if (reg_addr == REG_AW'(CH_BLOCK_BASE + 16 * i + 8))  reg_rdata = tag_a[i];
      if (reg_addr == REG_AW'(CH_BLOCK_BASE + 16 * i + 12)) reg_rdata = cmd_a[i];
      if (reg_addr == REG_AW'(BR_BLOCK_BASE + 4 * i))       reg_rdata = br_a[i];
    end
  end

  fd_window_check #(.BASE(MEM_BASE), .SIZE(MEM_SIZE), .SPAN(4 * DESC_WORDS)) u_ptr_win (
    .addr      (next_ptr),
    .in_window (ptr_ok)
  );

  fd_window_check #(.BASE(MEM_BASE), .SIZE(MEM_SIZE), .SPAN(0)) u_src_win (
    .addr      (sel_src),
    .in_window (src_ok)
  );

  fd_fetch_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .ch_enable     (ch_enable),
    .sel_link      (sel_link),
    .sel_br        (sel_br),
    .sel_src       (sel_src),
    .sel_cmd       (sel_cmd),
    .next_ptr      (next_ptr),
    .ptr_ok        (ptr_ok),
    .src_ok        (src_ok),
    .cur_ch        (cur_ch),
    .clr_src       (clr_src),
    .hw_we         (hw_we),
    .br_consume    (br_consume),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .fetch_busy    (fetch_busy),
    .frame_done    (frame_done),
    .branch_evt    (branch_evt),
    .bus_err_evt   (bus_err_evt),
    .load_evt      (load_evt),
    .load_len      (load_len),
    .load_pal      (load_pal)
  );

  assign branch_ch  = cur_ch;
  assign bus_err_ch = cur_ch;
  assign load_ch    = cur_ch;
endmodule

// File: rtl/fd_fetch_checker.sv
module fd_fetch_checker #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CH_W = 3,
  parameter logic [31:0] MEM_BASE = 32'h1000_0000,
  parameter logic [31:0] MEM_SIZE = 32'h0000_1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [31:0]     mem_req_addr,
  input logic            mem_rsp_ready,
  input logic            fetch_busy,
  input logic            frame_done,
  input logic            branch_evt,
  input logic            bus_err_evt,
  input logic [CH_W-1:0] bus_err_ch
);
  localparam logic [32:0] HI = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_single_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  p_req_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr >= MEM_BASE) && (({1'b0, mem_req_addr} + 33'd4) <= HI));

  p_req_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  p_events_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, branch_evt, bus_err_evt}));

  p_err_ch_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_evt |-> (bus_err_ch < CH_W'(NUM_CH)));

  p_done_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> fetch_busy);

  p_done_ends_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !fetch_busy);
endmodule

bind frame_desc_fetcher fd_fetch_checker #(
  .NUM_CH   (NUM_CH),
  .CH_W     (CH_W),
  .MEM_BASE (MEM_BASE),
  .MEM_SIZE (MEM_SIZE)
) u_fetch_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .fetch_busy    (fetch_busy),
  .frame_done    (frame_done),
  .branch_evt    (branch_evt),
  .bus_err_evt   (bus_err_evt),
  .bus_err_ch    (bus_err_ch)
);

// File: tb/test_frame_desc_fetcher.sv
module test_frame_desc_fetcher;
  localparam int NCH = 7;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] SIZE = 32'h0000_1000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [NCH-1:0] ch_enable = '0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        fetch_busy, frame_done, branch_evt, bus_err_evt, load_evt, load_pal;
  logic [2:0]  branch_ch, bus_err_ch, load_ch;
  logic [20:0] load_len;

  frame_desc_fetcher #(.NUM_CH(NCH), .MEM_BASE(BASE), .MEM_SIZE(SIZE)) i_frame_desc_fetcher (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_enable(ch_enable),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .fetch_busy(fetch_busy), .frame_done(frame_done),
    .branch_evt(branch_evt), .branch_ch(branch_ch),
    .bus_err_evt(bus_err_evt), .bus_err_ch(bus_err_ch),
    .load_evt(load_evt), .load_ch(load_ch), .load_len(load_len), .load_pal(load_pal)
  );

  // behavioural memory: one outstanding word, response held off by stall
  logic [31:0] mem [0:1023];
  logic        pend;
  logic [31:0] paddr;
  logic        stall = 1'b0;
  logic [31:0] pidx;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      paddr <= '0;
    end else begin
      if (mem_rsp_valid && mem_rsp_ready) pend <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend  <= 1'b1;
        paddr <= mem_req_addr;
      end
    end
  end
  assign pidx          = (paddr - BASE) >> 2;
  assign mem_req_ready = !pend;
  assign mem_rsp_valid = pend && !stall;
  assign mem_rsp_data  = mem[pidx[9:0]];

  // port monitor
  logic [31:0] req_log [0:255];
  logic [2:0]  ber_log [0:63];
  logic [2:0]  brl_log [0:63];
  logic [2:0]  ldc_log [0:63];
  logic [20:0] ldl_log [0:63];
  logic        ldp_log [0:63];
  int req_cnt = 0, ber_cnt = 0, br_cnt = 0, ld_cnt = 0, done_cnt = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        req_log[req_cnt[7:0]] <= mem_req_addr;
        req_cnt <= req_cnt + 1;
      end
      if (bus_err_evt) begin
        ber_log[ber_cnt[5:0]] <= bus_err_ch;
        ber_cnt <= ber_cnt + 1;
      end
      if (branch_evt) begin
        brl_log[br_cnt[5:0]] <= branch_ch;
        br_cnt <= br_cnt + 1;
      end
      if (load_evt) begin
        ldc_log[ld_cnt[5:0]] <= load_ch;
        ldl_log[ld_cnt[5:0]] <= load_len;
        ldp_log[ld_cnt[5:0]] <= load_pal;
        ld_cnt <= ld_cnt + 1;
      end
      if (frame_done) done_cnt <= done_cnt + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] off, input logic [31:0] nxt, input logic [31:0] src,
                          input logic [31:0] tag, input logic [31:0] cmd);
    mem[(off >> 2) + 0] = nxt;
    mem[(off >> 2) + 1] = src;
    mem[(off >> 2) + 2] = tag;
    mem[(off >> 2) + 3] = cmd;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic run_frame();
    int d0;
    d0 = done_cnt;
    pulse_frame();
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h200, v); chk("R1 link0 after reset", v, 0);
    rd(12'h100, v); chk("R1 branch0 after reset", v, 0);
    rd(12'h264, v); chk("R1 src6 after reset", v, 0);
    chk("R1 no request", {31'd0, mem_req_valid}, 0);
    chk("R1 idle", {31'd0, fetch_busy}, 0);
    chk("R1 no events", {29'd0, branch_evt, bus_err_evt, load_evt}, 0);
  endtask

  task automatic t_write_mask();
    logic [31:0] v;
    wr(12'h210, 32'hFFFF_FFFF); rd(12'h210, v); chk("R2 link mask", v, 32'hFFFF_FFF0);
    wr(12'h104, 32'hFFFF_FFFF); rd(12'h104, v); chk("R2 branch mask", v, 32'hFFFF_FFF3);
    wr(12'h104, 32'h0);
    wr(12'h214, 32'hDEAD_BEEF); rd(12'h214, v); chk("R2 source read-only", v, 0);
    wr(12'h218, 32'h1234_5678); rd(12'h218, v); chk("R2 tag read-only", v, 0);
    wr(12'h21C, 32'h0400_0000); rd(12'h21C, v); chk("R2 command read-only", v, 0);
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); chk("R2 unmapped reads zero", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int r0, l0, d0, b0;
    wr(12'h200, BASE + 32'h100);
    wr(12'h220, BASE + 32'h180);
    wr(12'h210, BASE + 32'h140);
    ch_enable = 7'b000_0101;
    r0 = req_cnt; l0 = ld_cnt; d0 = done_cnt; b0 = ber_cnt;
    pulse_frame();
    pulse_frame();  // arrives while busy: must be dropped
    while (done_cnt == d0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R10 busy low after done", {31'd0, fetch_busy}, 0);
    chk("R3 busy start ignored, one done", done_cnt - d0, 1);
    chk("R4 request count", req_cnt - r0, 8);
    for (int k = 0; k < 8; k++)
      chk("R4 request order", req_log[(r0 + k) % 256],
          ((k < 4) ? BASE + 32'h100 : BASE + 32'h180) + 32'(4 * (k % 4)));
    rd(12'h200, v); chk("R4 ch0 link", v, BASE + 32'h140);
    rd(12'h204, v); chk("R4 ch0 source", v, BASE + 32'h800);
    rd(12'h208, v); chk("R4 ch0 tag", v, 32'h11);
    rd(12'h20C, v); chk("R4 ch0 command", v, 32'h0400_0123);
    rd(12'h224, v); chk("R4 ch2 source", v, BASE + 32'h900);
    rd(12'h210, v); chk("R4 disabled ch1 link kept", v, BASE + 32'h140);
    rd(12'h214, v); chk("R3 disabled ch1 source zero", v, 0);
    chk("R9 load count", ld_cnt - l0, 2);
    chk("R9 load ch0", {29'd0, ldc_log[l0 % 64]}, 0);
    chk("R9 len ch0", {11'd0, ldl_log[l0 % 64]}, 32'h120);
    chk("R9 pal ch0", {31'd0, ldp_log[l0 % 64]}, 1);
    chk("R9 load ch2", {29'd0, ldc_log[(l0 + 1) % 64]}, 2);
    chk("R9 len ch2", {11'd0, ldl_log[(l0 + 1) % 64]}, 32'h400);
    chk("R9 pal ch2", {31'd0, ldp_log[(l0 + 1) % 64]}, 0);
    chk("R8 no bus error", ber_cnt - b0, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int r0;
    ch_enable = 7'b000_0001;
    r0 = req_cnt;
    run_frame();
    chk("R6 follows link", req_log[r0 % 256], BASE + 32'h140);
    rd(12'h204, v); chk("R6 chained source", v, BASE + 32'hA00);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    int r0, b0;
    ch_enable = 7'b000_0001;
    wr(12'h100, BASE + 32'h203);
    r0 = req_cnt; b0 = br_cnt;
    run_frame();
    chk("R5 branch address used", req_log[r0 % 256], BASE + 32'h200);
    chk("R5 branch event count", br_cnt - b0, 1);
    chk("R5 branch event channel", {29'd0, brl_log[b0 % 64]}, 0);
    rd(12'h100, v); chk("R5 request flag cleared", v, BASE + 32'h202);
    rd(12'h204, v); chk("R5 branch source", v, BASE + 32'hB00);
    r0 = req_cnt; b0 = br_cnt;
    run_frame();
    chk("R5 one-shot back to link", req_log[r0 % 256], BASE + 32'h100);
    chk("R5 no second branch event", br_cnt - b0, 0);
  endtask

  task automatic t_branch_quiet();
    logic [31:0] v;
    int r0, b0;
    wr(12'h100, BASE + 32'h141);
    r0 = req_cnt; b0 = br_cnt;
    run_frame();
    chk("R5 silent branch address", req_log[r0 % 256], BASE + 32'h140);
    chk("R5 silent branch no event", br_cnt - b0, 0);
    rd(12'h100, v); chk("R5 silent flag cleared", v, BASE + 32'h140);
  endtask

  task automatic t_window();
    logic [31:0] v;
    int r0, e0;
    wr(12'h230, BASE + SIZE);
    wr(12'h240, BASE + SIZE - 32'h10);
    ch_enable = 7'b001_1000;
    r0 = req_cnt; e0 = ber_cnt;
    run_frame();
    chk("R7 only in-window pointer fetched", req_cnt - r0, 4);
    chk("R7 boundary pointer used", req_log[r0 % 256], BASE + SIZE - 32'h10);
    chk("R8 one bus error", ber_cnt - e0, 1);
    chk("R8 bus error on ch3", {29'd0, ber_log[e0 % 64]}, 3);
    rd(12'h234, v); chk("R7 skipped source zero", v, 0);
    rd(12'h244, v); chk("R7 boundary source", v, BASE + 32'h10);
  endtask

  task automatic t_bad_src();
    int e0, l0;
    wr(12'h240, BASE + 32'h2C0);
    wr(12'h250, BASE + 32'h240);
    wr(12'h260, BASE + 32'h280);
    ch_enable = 7'b111_0000;
    e0 = ber_cnt; l0 = ld_cnt;
    run_frame();
    chk("R8 two bus errors", ber_cnt - e0, 2);
    chk("R8 zero source ch5", {29'd0, ber_log[e0 % 64]}, 5);
    chk("R8 outside source ch6", {29'd0, ber_log[(e0 + 1) % 64]}, 6);
    chk("R9 three loads", ld_cnt - l0, 3);
  endtask

  task automatic t_all_off();
    logic [31:0] v;
    int r0;
    rd(12'h244, v); chk("R3 ch4 source before", v, BASE + SIZE);
    ch_enable = '0;
    r0 = req_cnt;
    run_frame();
    chk("R3 no requests", req_cnt - r0, 0);
    rd(12'h244, v); chk("R3 source cleared by frame start", v, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    int d0;
    wr(12'h200, BASE + 32'h100);
    ch_enable = 7'b000_0001;
    stall = 1'b1;
    d0 = done_cnt;
    pulse_frame();
    while (!(pend && paddr == BASE + 32'h100)) @(negedge clk);
    chk("R11 no request while awaiting response", {31'd0, mem_req_valid}, 0);
    stall = 1'b0;
    reg_wr_en = 1'b1; reg_addr = 12'h200; reg_wdata = BASE + 32'h345;
    @(negedge clk);
    reg_wr_en = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    rd(12'h200, v); chk("R12 software write wins", v, BASE + 32'h340);
    rd(12'h204, v); chk("R12 fetch continues", v, BASE + 32'h800);
  endtask

  initial begin
    bit wd = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    put_desc(32'h100, BASE + 32'h140, BASE + 32'h800, 32'h11, 32'h0400_0123);
    put_desc(32'h140, BASE + 32'h100, BASE + 32'hA00, 32'h33, 32'h0);
    put_desc(32'h180, BASE + 32'h180, BASE + 32'h900, 32'h22, 32'h0000_0400);
    put_desc(32'h200, BASE + 32'h100, BASE + 32'hB00, 32'h44, 32'h10);
    put_desc(32'h240, 32'h0, 32'h0, 32'h55, 32'h0);
    put_desc(32'h280, 32'h0, 32'h2000_0000, 32'h66, 32'h0);
    put_desc(32'h2C0, 32'h0, BASE + SIZE, 32'h88, 32'h0);
    put_desc(32'hFF0, 32'h0, BASE + 32'h10, 32'h77, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_write_mask();
        t_basic();
        t_chain();
        t_branch();
        t_branch_quiet();
        t_window();
        t_bad_src();
        t_all_off();
        t_collision();
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule